// File: doc/BRIEF.md
# Interrupt and Reset Entry Sequencer

This block sits beside an 8-bit processor core and decides, each time the core reaches an instruction boundary, whether to enter an interrupt. The choice is between a non-maskable request, a maskable request or nothing. When an entry is taken, the block saves the return address and status on a fixed-page stack through a byte-wide memory port. It then fetches the handler address from the matching vector and hands the core a new program counter, status byte and stack pointer. Every entry takes seven cycles.

The same seven-cycle engine performs the reset entry. This happens once after the asynchronous reset is released, and again whenever a reset request arrives while the block is idle. A reset entry writes nothing to the stack, loads the reset vector and leaves only the interrupt-disable flag set in the status. It also tells the core to leave its halted state.

Maskable requests come from a bank of level sources and from a one-shot request. Each level source is set and cleared individually. The non-maskable line is latched on its rising edge. The interrupt-disable flag that gates the maskable path is the one the core presented at the previous boundary, or the one produced by the last entry. It is not the flag presented at the current boundary.

Top module: `irq_entry_seq`

## Requirements
- R1: A decision is made only in a cycle with `boundary_i` high while `busy_o` is low and `reset_req_i` is low. When an entry is taken, `busy_o` is high for exactly the following 7 cycles, and `done_o` is high only in the last of them. When no entry is taken, `busy_o` stays low.
- R2: A latched non-maskable request wins over any maskable request. Its vector low byte is at 0xFFFA and its high byte at 0xFFFB. `status_o` equals the `status_i` presented at that boundary.
- R3: The maskable entry is taken only if bit 2 (interrupt disable) was clear in the status recorded at the previous decision. That recorded status is the `status_i` of the last boundary, the status after the last entry, or set after any reset. The vector is 0xFFFE (low byte) and 0xFFFF (high byte). `status_o` equals `status_i` with bit 2 set.
- R4: During the first three busy cycles of an interrupt entry, the block makes three writes. It writes PC[15:8] to 0x0100+S, then PC[7:0] to 0x0100+(S-1), then `status_i` with bit 4 cleared and bit 5 set to 0x0100+(S-2). S is the `sp_i` taken at the boundary, and S wraps within 8 bits. `sp_o` drops by one after each write and ends at S-3.
- R5: While `halted_i` is high, no interrupt entry is taken.
- R6: `nmi_i` is latched on its rising edge only. A line that stays high gives a single entry.
- R7: Any pending request seen at a decision causes the pending non-maskable and one-shot requests to be discarded, whether or not an entry follows. This covers a masked or halted case, and it covers a one-shot that loses to a non-maskable entry. Level source bits stay set until a pulse on `irq_clr_i` clears them. A set and a clear of the same bit in one cycle leaves the bit set.
- R8: A reset entry runs after `rst_n` is released and on `reset_req_i` while the block is idle. It lasts 7 cycles and makes no writes. It loads the vector from 0xFFFC (low byte) and 0xFFFD (high byte). It gives `status_o` = 0x04 and `sp_o` = the `sp_i` at the request, or 0x00 after power-on. It raises `halt_release_o` together with `done_o`.
- R9: Each entry reads its vector low byte in busy cycle 4 and its high byte in busy cycle 5, with `mem_re_o` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boundary_i | input | 1 | Core is at an instruction boundary |
| reset_req_i | input | 1 | Start a reset entry |
| halted_i | input | 1 | Core is halted |
| nmi_i | input | 1 | Non-maskable request line |
| oneshot_i | input | 1 | One-shot maskable request pulse |
| irq_set_i | input | NSRC | Per-source level request set |
| irq_clr_i | input | NSRC | Per-source level request clear |
| pc_i | input | 16 | Return address at the boundary |
| status_i | input | 8 | Status byte at the boundary |
| sp_i | input | 8 | Stack pointer at the boundary |
| mem_addr_o | output | 16 | Memory address |
| mem_we_o | output | 1 | Memory write strobe |
| mem_re_o | output | 1 | Memory read strobe |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rdata_i | input | 8 | Memory read data, same cycle |
| busy_o | output | 1 | Entry sequence in progress |
| done_o | output | 1 | Last cycle of an entry; results valid |
| pc_o | output | 16 | New program counter |
| status_o | output | 8 | New status byte |
| sp_o | output | 8 | Stack pointer |
| halt_release_o | output | 1 | Core leaves halted state |

## Verification
All 256 status values are swept in pairs of boundaries. The first boundary of each pair records the disable flag, and the second carries a level request with the inverted status. This separates gating by the recorded flag from gating by the current flag. Stack pointers 0 through 255 are covered, including the wrap below 0x0100.

Non-maskable entries are run both with and without a competing level request, to show priority and that the status passes through unchanged. A line held high shows that only its rising edge counts, and a halted boundary shows that a request is blocked and then lost. The one-shot is tried once unmasked and once masked, and a second boundary afterwards tells consumption apart from retention. Level requests are taken again after an entry, which shows they persist. Resets at power-on and by request cover the fixed status, the stack pointer that is kept, the absence of writes and the re-set disable flag.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  typedef enum logic [1:0] {
    ENT_RESET = 2'd0,
    ENT_NMI   = 2'd1,
    ENT_IRQ   = 2'd2
  } entry_kind_e;

  localparam int FLAG_I       = 2;
  localparam int FLAG_B       = 4;
  localparam int FLAG_U       = 5;
  localparam int ENTRY_CYCLES = 7;
  localparam int ADDR_W       = 16;
  localparam int DATA_W       = 8;
endpackage

// File: rtl/irq_req_tracker.sv
module irq_req_tracker
  import irq_seq_pkg::*;
#(
  parameter int NSRC = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            eval_i,
  input  logic            rst_entry_i,
  input  logic [7:0]      status_i,
  input  logic            halted_i,
  input  logic            nmi_i,
  input  logic            oneshot_i,
  input  logic [NSRC-1:0] lvl_set_i,
  input  logic [NSRC-1:0] lvl_clr_i,
  output logic            take_nmi_o,
  output logic            take_irq_o
);

  logic [NSRC-1:0] lvl_q, lvl_d;
  logic            nmi_line_q;
  logic            nmi_pend_q, nmi_pend_d;
  logic            os_pend_q, os_pend_d;
  logic            prev_i_q, prev_i_d;
  logic            prev_en;
  logic            any_req, mask_req, consume;

  always_comb begin
    mask_req   = os_pend_q | (|lvl_q);
    any_req    = nmi_pend_q | mask_req;
    take_nmi_o = eval_i & nmi_pend_q & ~halted_i;
    take_irq_o = eval_i & ~nmi_pend_q & mask_req & ~prev_i_q & ~halted_i;
    consume    = eval_i & any_req;

    nmi_pend_d = (nmi_pend_q & ~consume) | (nmi_i & ~nmi_line_q);
    os_pend_d  = (os_pend_q & ~consume) | oneshot_i;
    lvl_d      = (lvl_q & ~lvl_clr_i) | lvl_set_i;

    prev_en  = rst_entry_i | eval_i;
    prev_i_d = rst_entry_i ? 1'b1 : (take_irq_o | status_i[FLAG_I]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q      <= '0;
      nmi_line_q <= 1'b0;
      nmi_pend_q <= 1'b0;
      os_pend_q  <= 1'b0;
      prev_i_q   <= 1'b1;
    end else begin
      lvl_q      <= lvl_d;
      nmi_line_q <= nmi_i;
      nmi_pend_q <= nmi_pend_d;
      os_pend_q  <= os_pend_d;
      if (prev_en) prev_i_q <= prev_i_d;
    end
  end

  // R6: a new non-maskable pending only follows a low-to-high step of the line
  assert_nmi_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_pend_q && !$past(nmi_pend_q)) |-> ($past(nmi_i) && !$past(nmi_line_q)));

  // R7: a decision that sees requests leaves no one-shot pending unless a new pulse came
  assert_consume_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_i && any_req && !oneshot_i) |=> !os_pend_q);

  // R7: a level bit only drops on a clear pulse
  assert_level_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|(lvl_q & ~lvl_clr_i)) |=> (|lvl_q));

endmodule

// File: rtl/irq_entry_fsm.sv
module irq_entry_fsm
  import irq_seq_pkg::*;
#(
  parameter logic [7:0]        STACK_PAGE = 8'h01,
  parameter logic [ADDR_W-1:0] VEC_NMI    = 16'hFFFA,
  parameter logic [ADDR_W-1:0] VEC_RST    = 16'hFFFC,
  parameter logic [ADDR_W-1:0] VEC_IRQ    = 16'hFFFE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  entry_kind_e       kind_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [7:0]        status_i,
  input  logic [7:0]        sp_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_we_o,
  output logic              mem_re_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic [7:0]        status_o,
  output logic [7:0]        sp_o,
  output logic              halt_release_o
);

  localparam int          SW   = $clog2(ENTRY_CYCLES);
  localparam logic [SW-1:0] LAST = SW'(ENTRY_CYCLES - 1);
  localparam logic [7:0]  IMASK = 8'(1 << FLAG_I);
  localparam logic [7:0]  BMASK = 8'(1 << FLAG_B);
  localparam logic [7:0]  UMASK = 8'(1 << FLAG_U);

  logic              busy_q, busy_d;
  logic [SW-1:0]     step_q, step_d;
  entry_kind_e       kind_q, kind_d;
  logic [ADDR_W-1:0] pc_q, pc_d;
  logic [7:0]        push_q, push_d;
  logic [7:0]        nst_q, nst_d;
  logic [7:0]        sp_q, sp_d;
  logic [ADDR_W-1:0] vec_base;
  logic              uses_stack;

  always_comb begin
    busy_d = busy_q;
    step_d = step_q;
    kind_d = kind_q;
    pc_d   = pc_q;
    push_d = push_q;
    nst_d  = nst_q;
    sp_d   = sp_q;

    mem_we_o    = 1'b0;
    mem_re_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;

    case (kind_q)
      ENT_NMI: vec_base = VEC_NMI;
      ENT_IRQ: vec_base = VEC_IRQ;
      default: vec_base = VEC_RST;
    endcase
    uses_stack = (kind_q != ENT_RESET);

    if (busy_q) begin
      case (step_q)
        SW'(0): begin
          mem_we_o    = uses_stack;
          mem_addr_o  = {STACK_PAGE, sp_q};
          mem_wdata_o = pc_q[15:8];
        end
        SW'(1): begin
          mem_we_o    = uses_stack;
          mem_addr_o  = {STACK_PAGE, sp_q};
          mem_wdata_o = pc_q[7:0];
        end
        SW'(2): begin
          mem_we_o    = uses_stack;
          mem_addr_o  = {STACK_PAGE, sp_q};
          mem_wdata_o = push_q;
        end
        SW'(3): begin
          mem_re_o   = 1'b1;
          mem_addr_o = vec_base;
          pc_d[7:0]  = mem_rdata_i;
        end
        SW'(4): begin
          mem_re_o   = 1'b1;
          mem_addr_o = vec_base + 16'd1;
          pc_d[15:8] = mem_rdata_i;
        end
        default: ;
      endcase
      if (mem_we_o) sp_d = sp_q - 8'd1;
      if (step_q == LAST) busy_d = 1'b0;
      else                step_d = step_q + SW'(1);
    end else if (start_i) begin
      busy_d = 1'b1;
      step_d = '0;
      kind_d = kind_i;
      pc_d   = pc_i;
      sp_d   = sp_i;
      push_d = (status_i & ~BMASK) | UMASK;
      case (kind_i)
        ENT_NMI: nst_d = status_i;
        ENT_IRQ: nst_d = status_i | IMASK;
        default: nst_d = IMASK;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b1;
      step_q <= '0;
      kind_q <= ENT_RESET;
      pc_q   <= '0;
      push_q <= '0;
      nst_q  <= IMASK;
      sp_q   <= '0;
    end else begin
      busy_q <= busy_d;
      step_q <= step_d;
      kind_q <= kind_d;
      pc_q   <= pc_d;
      push_q <= push_d;
      nst_q  <= nst_d;
      sp_q   <= sp_d;
    end
  end

  assign busy_o         = busy_q;
  assign done_o         = busy_q && (step_q == LAST);
  assign pc_o           = pc_q;
  assign status_o       = nst_q;
  assign sp_o           = sp_q;
  assign halt_release_o = done_o && (kind_q == ENT_RESET);

  // R1: the sequence ends right after its final cycle
  assert_busy_end_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_o);

  // R1: the step counter never runs past the last cycle
  assert_step_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (step_q <= LAST));

  // R4: every write lands in the stack page
  assert_stack_page_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> (mem_addr_o[15:8] == STACK_PAGE));

  // R4: each write moves the stack pointer down by one
  assert_sp_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |=> (sp_o == $past(sp_o) - 8'd1));

  // R3: a maskable entry always hands back a disabled status
  assert_irq_sets_i_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && kind_q == ENT_IRQ) |-> status_o[FLAG_I]);

  // R8: a reset entry never writes
  assert_reset_nowrite_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && kind_q == ENT_RESET) |-> !mem_we_o);

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_seq_pkg::*;
#(
  parameter int                NSRC       = 4,
  parameter logic [7:0]        STACK_PAGE = 8'h01,
  parameter logic [ADDR_W-1:0] VEC_NMI    = 16'hFFFA,
  parameter logic [ADDR_W-1:0] VEC_RST    = 16'hFFFC,
  parameter logic [ADDR_W-1:0] VEC_IRQ    = 16'hFFFE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boundary_i,
  input  logic              reset_req_i,
  input  logic              halted_i,
  input  logic              nmi_i,
  input  logic              oneshot_i,
  input  logic [NSRC-1:0]   irq_set_i,
  input  logic [NSRC-1:0]   irq_clr_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [7:0]        status_i,
  input  logic [7:0]        sp_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_we_o,
  output logic              mem_re_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic [7:0]        status_o,
  output logic [7:0]        sp_o,
  output logic              halt_release_o
);

  logic        eval, rst_entry, take_nmi, take_irq, start;
  entry_kind_e kind;

  always_comb begin
    eval      = boundary_i & ~busy_o & ~reset_req_i;
    rst_entry = reset_req_i & ~busy_o;
    start     = rst_entry | take_nmi | take_irq;
    if (reset_req_i)   kind = ENT_RESET;
    else if (take_nmi) kind = ENT_NMI;
    else               kind = ENT_IRQ;
  end

  irq_req_tracker #(.NSRC(NSRC)) u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .eval_i     (eval),
    .rst_entry_i(rst_entry),
    .status_i   (status_i),
    .halted_i   (halted_i),
    .nmi_i      (nmi_i),
    .oneshot_i  (oneshot_i),
    .lvl_set_i  (irq_set_i),
    .lvl_clr_i  (irq_clr_i),
    .take_nmi_o (take_nmi),
    .take_irq_o (take_irq)
  );

  irq_entry_fsm #(
    .STACK_PAGE(STACK_PAGE),
    .VEC_NMI   (VEC_NMI),
    .VEC_RST   (VEC_RST),
    .VEC_IRQ   (VEC_IRQ)
  ) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start),
    .kind_i        (kind),
    .pc_i          (pc_i),
    .status_i      (status_i),
    .sp_i          (sp_i),
    .mem_addr_o    (mem_addr_o),
    .mem_we_o      (mem_we_o),
    .mem_re_o      (mem_re_o),
    .mem_wdata_o   (mem_wdata_o),
    .mem_rdata_i   (mem_rdata_i),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .pc_o          (pc_o),
    .status_o      (status_o),
    .sp_o          (sp_o),
    .halt_release_o(halt_release_o)
  );

  // R5: a halted boundary without a reset request starts nothing
  assert_halt_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary_i && halted_i && !busy_o && !reset_req_i) |=> !busy_o);

  // R1: nothing starts while idle unless a boundary or reset request was present
  assert_start_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !boundary_i && !reset_req_i) |=> !busy_o);

endmodule

// File: tb/tb_irq_entry_seq.sv
module tb_irq_entry_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n;
  logic        boundary, reset_req, halted, nmi, oneshot;
  logic [3:0]  lset, lclr;
  logic [15:0] pc_in;
  logic [7:0]  st_in, sp_in;
  logic [15:0] maddr;
  logic        mwe, mre;
  logic [7:0]  mwd, mrd;
  logic        busy, done, hrel;
  logic [15:0] pc_out;
  logic [7:0]  st_out, sp_out;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // logs filled by the negedge monitor
  int          bc, dn, wn, rn;
  bit          hr_seen;
  logic [15:0] wa [0:7];
  logic [7:0]  wd [0:7];
  logic [15:0] ra [0:7];
  logic [15:0] g_pc;
  logic [7:0]  g_st, g_sp;

  function automatic logic [7:0] vb(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  assign mrd = vb(maddr);

  irq_entry_seq dut (
    .clk(clk), .rst_n(rst_n), .boundary_i(boundary), .reset_req_i(reset_req),
    .halted_i(halted), .nmi_i(nmi), .oneshot_i(oneshot), .irq_set_i(lset),
    .irq_clr_i(lclr), .pc_i(pc_in), .status_i(st_in), .sp_i(sp_in),
    .mem_addr_o(maddr), .mem_we_o(mwe), .mem_re_o(mre), .mem_wdata_o(mwd),
    .mem_rdata_i(mrd), .busy_o(busy), .done_o(done), .pc_o(pc_out),
    .status_o(st_out), .sp_o(sp_out), .halt_release_o(hrel)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (rst_n) begin
      if (busy) bc++;
      if (mwe && wn < 8) begin wa[wn] = maddr; wd[wn] = mwd; wn++; end
      if (mre && rn < 8) begin ra[rn] = maddr; rn++; end
      if (done) begin
        dn++; g_pc = pc_out; g_st = st_out; g_sp = sp_out;
        if (hrel) hr_seen = 1;
      end
    end
  end

  task automatic clear_logs();
    bc = 0; dn = 0; wn = 0; rn = 0; hr_seen = 0;
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // kind: 0 none, 1 non-maskable, 2 maskable, 3 reset
  task automatic expect_entry(input int kind, input logic [15:0] pc,
                              input logic [7:0] p, input logic [7:0] s,
                              input string req);
    logic [15:0] base, epc;
    logic [7:0]  est, esp, epush;
    if (kind == 0) begin
      chk(bc == 0, req, "busy cycles (none)", 32'(bc), 0);
      chk(wn == 0 && dn == 0, req, "writes (none)", 32'(wn), 0);
      return;
    end
    base  = (kind == 1) ? 16'hFFFA : (kind == 2) ? 16'hFFFE : 16'hFFFC;
    epc   = {vb(base + 16'd1), vb(base)};
    est   = (kind == 1) ? p : (kind == 2) ? (p | 8'h04) : 8'h04;
    esp   = (kind == 3) ? s : s - 8'd3;
    epush = (p & 8'hEF) | 8'h20;
    chk(bc == 7, "R1", "busy cycles", 32'(bc), 7);
    chk(dn == 1, "R1", "done pulses", 32'(dn), 1);
    chk(g_pc == epc, req, "pc_o", 32'(g_pc), 32'(epc));
    chk(g_st == est, req, "status_o", 32'(g_st), 32'(est));
    chk(g_sp == esp, (kind == 3) ? "R8" : "R4", "sp_o", 32'(g_sp), 32'(esp));
    chk(rn == 2 && ra[0] == base && ra[1] == base + 16'd1, "R9", "vector reads",
        32'(ra[0]), 32'(base));
    if (kind == 3) begin
      chk(wn == 0, "R8", "reset writes", 32'(wn), 0);
      chk(hr_seen, "R8", "halt release", 32'(hr_seen), 1);
    end else begin
      chk(wn == 3, "R4", "write count", 32'(wn), 3);
      chk(wa[0] == {8'h01, s} && wd[0] == pc[15:8], "R4", "push pc high",
          32'({wa[0], wd[0]}), 32'({8'h01, s, pc[15:8]}));
      chk(wa[1] == {8'h01, s - 8'd1} && wd[1] == pc[7:0], "R4", "push pc low",
          32'({wa[1], wd[1]}), 32'({8'h01, s - 8'd1, pc[7:0]}));
      chk(wa[2] == {8'h01, s - 8'd2} && wd[2] == epush, "R4", "push status",
          32'({wa[2], wd[2]}), 32'({8'h01, s - 8'd2, epush}));
      chk(!hr_seen, "R8", "no halt release", 32'(hr_seen), 0);
    end
  endtask

  task automatic at_boundary(input logic [15:0] pc, input logic [7:0] p,
                             input logic [7:0] s);
    @(negedge clk);
    pc_in = pc; st_in = p; sp_in = s; boundary = 1'b1;
    clear_logs();
    @(negedge clk);
    boundary = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic do_reset_req(input logic [7:0] s);
    @(negedge clk);
    sp_in = s; reset_req = 1'b1;
    clear_logs();
    @(negedge clk);
    reset_req = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic pulse_set(input logic [3:0] m);
    @(negedge clk); lset = m;
    @(negedge clk); lset = '0;
  endtask

  task automatic pulse_clr(input logic [3:0] m);
    @(negedge clk); lclr = m;
    @(negedge clk); lclr = '0;
  endtask

  task automatic pulse_oneshot();
    @(negedge clk); oneshot = 1'b1;
    @(negedge clk); oneshot = 1'b0;
  endtask

  task automatic nmi_level(input logic v);
    @(negedge clk); nmi = v;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; boundary = 0; reset_req = 0; halted = 0; nmi = 0; oneshot = 0;
    lset = '0; lclr = '0; pc_in = '0; st_in = '0; sp_in = '0;
    clear_logs();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    clear_logs();
    repeat (9) @(negedge clk);
    // R8 power-on reset entry, stack pointer 0
    expect_entry(3, 16'h0000, 8'h00, 8'h00, "R8");

    // R3 right after reset the recorded flag is set: level request is held off
    pulse_set(4'b0001);
    at_boundary(16'h1234, 8'h00, 8'h80);
    expect_entry(0, 16'h1234, 8'h00, 8'h80, "R3");
    pulse_clr(4'b0001);

    // R3 sweep of recorded status against inverted current status, all stack pointers
    for (int p = 0; p < 256; p++) begin
      logic [7:0]  pv, q;
      logic [15:0] pc;
      pv = 8'(p);
      q  = ~pv;
      pc = {8'(p * 3), pv ^ 8'hA5};
      at_boundary(pc, pv, pv);
      expect_entry(0, pc, pv, pv, "R1");
      pulse_set(4'(1 << (p % 4)));
      at_boundary(pc, q, pv);
      expect_entry(pv[2] ? 0 : 2, pc, q, pv, "R3");
      pulse_clr(4'hF);
    end

    // R2 non-maskable entries, some with a competing level request
    for (int i = 0; i < 16; i++) begin
      logic [7:0]  p;
      logic [15:0] pc;
      p  = 8'(i * 17);
      pc = {8'(i), 8'(255 - i)};
      at_boundary(pc, 8'h00, 8'h10);
      if (i % 2 == 1) pulse_set(4'(1 << (i % 4)));
      nmi_level(1'b1);
      at_boundary(pc, p, 8'(8'hF0 + i));
      expect_entry(1, pc, p, 8'(8'hF0 + i), "R2");
      nmi_level(1'b0);
      pulse_clr(4'hF);
    end

    // R6 held line gives no second entry; a fresh rise does
    nmi_level(1'b1);
    at_boundary(16'hA000, 8'h00, 8'h50);
    expect_entry(1, 16'hA000, 8'h00, 8'h50, "R6");
    at_boundary(16'hA001, 8'h00, 8'h50);
    expect_entry(0, 16'hA001, 8'h00, 8'h50, "R6");
    nmi_level(1'b0);
    nmi_level(1'b1);
    at_boundary(16'hA002, 8'h00, 8'h40);
    expect_entry(1, 16'hA002, 8'h00, 8'h40, "R6");
    nmi_level(1'b0);

    // R5 halted blocks the entry; R7 and the request is then gone
    halted = 1'b1;
    nmi_level(1'b1);
    at_boundary(16'hB000, 8'h00, 8'h30);
    expect_entry(0, 16'hB000, 8'h00, 8'h30, "R5");
    halted = 1'b0;
    at_boundary(16'hB001, 8'h00, 8'h30);
    expect_entry(0, 16'hB001, 8'h00, 8'h30, "R7");
    nmi_level(1'b0);

    // R7 one-shot taken once, then consumed
    at_boundary(16'hC000, 8'h00, 8'h60);
    pulse_oneshot();
    at_boundary(16'hC001, 8'h04, 8'h60);
    expect_entry(2, 16'hC001, 8'h04, 8'h60, "R7");
    at_boundary(16'hC002, 8'h00, 8'h5D);
    expect_entry(0, 16'hC002, 8'h00, 8'h5D, "R3");
    at_boundary(16'hC003, 8'h00, 8'h5D);
    expect_entry(0, 16'hC003, 8'h00, 8'h5D, "R7");

    // R7 masked one-shot is discarded
    at_boundary(16'hC100, 8'h04, 8'h60);
    pulse_oneshot();
    at_boundary(16'hC101, 8'h00, 8'h60);
    expect_entry(0, 16'hC101, 8'h00, 8'h60, "R7");
    at_boundary(16'hC102, 8'h00, 8'h60);
    expect_entry(0, 16'hC102, 8'h00, 8'h60, "R7");

    // R7 one-shot losing to a non-maskable entry is discarded too
    pulse_oneshot();
    nmi_level(1'b1);
    at_boundary(16'hC200, 8'h00, 8'h70);
    expect_entry(1, 16'hC200, 8'h00, 8'h70, "R2");
    nmi_level(1'b0);
    at_boundary(16'hC201, 8'h00, 8'h6D);
    expect_entry(0, 16'hC201, 8'h00, 8'h6D, "R7");

    // R7 level request persists across entries until cleared
    pulse_set(4'b0100);
    at_boundary(16'hD000, 8'h00, 8'h90);
    expect_entry(2, 16'hD000, 8'h00, 8'h90, "R7");
    at_boundary(16'hD001, 8'h00, 8'h8D);
    expect_entry(0, 16'hD001, 8'h00, 8'h8D, "R3");
    at_boundary(16'hD002, 8'h00, 8'h8D);
    expect_entry(2, 16'hD002, 8'h00, 8'h8D, "R7");
    pulse_clr(4'b0100);
    at_boundary(16'hD003, 8'h00, 8'h8A);
    at_boundary(16'hD004, 8'h00, 8'h8A);
    expect_entry(0, 16'hD004, 8'h00, 8'h8A, "R7");

    // R7 set and clear in the same cycle leaves the bit set
    @(negedge clk); lset = 4'b1000; lclr = 4'b1000;
    @(negedge clk); lset = '0; lclr = '0;
    at_boundary(16'hD100, 8'h00, 8'h22);
    expect_entry(2, 16'hD100, 8'h00, 8'h22, "R7");
    pulse_clr(4'hF);

    // R8 requested reset while halted keeps the stack pointer
    halted = 1'b1;
    do_reset_req(8'h37);
    expect_entry(3, 16'h0000, 8'h00, 8'h37, "R8");
    halted = 1'b0;

    // R8 reset leaves the disable flag recorded
    pulse_set(4'b0010);
    at_boundary(16'hE000, 8'h00, 8'h37);
    expect_entry(0, 16'hE000, 8'h00, 8'h37, "R8");
    at_boundary(16'hE001, 8'h00, 8'h37);
    expect_entry(2, 16'hE001, 8'h00, 8'h37, "R3");
    pulse_clr(4'hF);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule